// File: doc/BRIEF.md
# Inter-Processor Doorbell Fabric

This block lets a group of processor agents ring each other. Every agent owns a small register window, reached through one shared memory-mapped request port. An agent rings a peer by writing the peer's identity bit to its own trigger register. The request then shows as pending in the peer's interrupt status. It also shows as outstanding in the sender's own status view. Both stay set until the peer acknowledges. Each agent drives one interrupt line, and a per-agent mask gates that line.

There are eleven agents. Each has a fixed one-hot identity bit in a 32-bit word:

| Agent | Identity bit |
|---|---|
| 0 | 0x1 |
| 1 | 0x100 |
| 2 | 0x200 |
| 3 | 0x10000 |
| 4 | 0x20000 |
| 5 | 0x40000 |
| 6 | 0x80000 |
| 7 to 10 | 0x1000000 to 0x8000000 |

Agents 3, 5 and 6 accept only secure requesters. A non-secure request is refused if it selects the window of one of these agents. It is also refused if it is a write whose data holds one of their identity bits. A request naming an agent index that does not exist is refused with its own error code.

The sender polls its outstanding bit until it reads zero, which gives a blocking notify. The receiver's write-one-to-clear acknowledge is the only event that clears both views of a request.

Top module: `ipi_doorbell_fabric`

## Requirements
- R1: After reset every interrupt status word reads zero. Every mask word reads 0x0F0F0301, which is all eleven identity bits set, so all sources are masked. All irq outputs are low.
- R2: A granted write by agent L to word 0 (trigger) sets bit id(L) in the interrupt status (word 4) of every agent R whose identity bit is in the data.
- R3: A read of word 1 (outstanding) by agent L returns id(R) for every agent R whose interrupt status holds id(L).
- R4: A granted write to word 4 clears the status bits that are written as ones. Bits written as zero are kept. After the clear, the sender's outstanding bit for that request reads zero.
- R5: A granted write to word 7 (disable) sets the mask bits that are written as ones. A granted write to word 6 (enable) clears them. Word 5 reads the mask.
- R6: irq[a] is high exactly when agent a has a status bit set whose mask bit is clear. It reflects a granted write in the cycle after that write is accepted.
- R7: Words 0, 6 and 7, and the unused words 2 and 3, read as zero. Writes to words 1, 2 and 3 change no state.
- R8: A request whose agent index is 11 or more returns rsp_code 1 and rdata zero, and changes no state.
- R9: A non-secure request to the window of agent 3, 5 or 6 returns rsp_code 2 and changes no state. So does a non-secure write whose data holds bit 0x10000, 0x40000 or 0x80000. The same requests from a secure requester are granted with rsp_code 0.
- R10: Each cycle with req_valid high produces rsp_valid high in the next cycle, and only then. Writes return rdata zero.
- R11: Bits of the write data that are not an identity bit have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_secure | input | 1 | The requester is secure |
| req_agent | input | 4 | Index of the agent whose window is addressed |
| req_word | input | 3 | Register word in the window (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | The response for the previous cycle's request is valid |
| rsp_code | output | 2 | 0 granted, 1 index out of range, 2 refused for security |
| rsp_rdata | output | 32 | Read data; zero for writes and refused requests |
| irq | output | 11 | One interrupt line per agent |

## Verification
A status bit in the wrong state shows up in two places. It appears in the receiver's word 4 read, and again in the sender's word 1 read, because the outstanding view is computed from the same bit. Once the receiver enables that source, it also shows on the irq line in the next cycle. A wrong mask bit shows on word 5 and on irq in the cycle after the enable or disable write. A permission or range check that lets a request through becomes visible one access later, when a read shows the state that was changed.

// File: rtl/ipi_pkg.sv
`timescale 1ns/1ps
package ipi_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned AGENTS = 11;

  // register words inside one agent window (byte offset / 4)
  typedef enum logic [2:0] {
    W_TRIG  = 3'd0,
    W_OUTST = 3'd1,
    W_STAT  = 3'd4,
    W_MASK  = 3'd5,
    W_EN    = 3'd6,
    W_DIS   = 3'd7
  } word_e;

  typedef enum logic [1:0] {
    RSP_OK    = 2'd0,
    RSP_RANGE = 2'd1,
    RSP_PERM  = 2'd2
  } rsp_e;

  // bit position of an agent's identity: groups by agent class
  function automatic int unsigned id_pos(int unsigned i);
    if (i == 0)     return 0;
    else if (i < 3) return i + 7;
    else if (i < 7) return i + 13;
    else            return i + 17;
  endfunction

  function automatic logic [DATA_W-1:0] id_bit(int unsigned i);
    return DATA_W'(1) << id_pos(i);
  endfunction

  function automatic logic secure_only(int unsigned i);
    return (i == 3) || (i == 5) || (i == 6);
  endfunction

  function automatic logic [DATA_W-1:0] all_ids(int unsigned n);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int unsigned i = 0; i < n; i++) v |= id_bit(i);
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] secure_ids(int unsigned n);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int unsigned i = 0; i < n; i++)
      if (secure_only(i)) v |= id_bit(i);
    return v;
  endfunction

endpackage

// File: rtl/ipi_rst_sync.sv
`timescale 1ns/1ps
module ipi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/ipi_access_check.sv
`timescale 1ns/1ps
module ipi_access_check
  import ipi_pkg::*;
#(
  parameter int unsigned NUM_AGENTS = AGENTS,
  parameter int unsigned DW         = DATA_W,
  parameter int unsigned IDX_W      = $clog2(NUM_AGENTS)
) (
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_secure,
  input  logic [IDX_W-1:0] req_agent,
  input  logic [DW-1:0]    req_wdata,
  output logic             grant_o,
  output logic [1:0]       code_o
);
  localparam logic [DW-1:0] SEC_IDS = DW'(secure_ids(NUM_AGENTS));

  logic range_bad;
  logic local_sec;
  logic remote_sec;
  logic perm_bad;

  always_comb begin
    range_bad = 1'b1;
    local_sec = 1'b0;
    for (int unsigned a = 0; a < NUM_AGENTS; a++) begin
      if (req_agent == IDX_W'(a)) begin
        range_bad = 1'b0;
        local_sec = secure_only(a);
      end
    end
    remote_sec = req_write && ((req_wdata & SEC_IDS) != '0);
    perm_bad   = !req_secure && (local_sec || remote_sec);
    grant_o    = req_valid && !range_bad && !perm_bad;
    if (range_bad)     code_o = RSP_RANGE;
    else if (perm_bad) code_o = RSP_PERM;
    else               code_o = RSP_OK;
  end
endmodule

// File: rtl/ipi_agent_slot.sv
`timescale 1ns/1ps
module ipi_agent_slot #(
  parameter int unsigned         DW         = 32,
  parameter logic [DW-1:0]       RESET_MASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  input  logic [DW-1:0] mask_set_i,
  input  logic [DW-1:0] mask_clr_i,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] mask_o,
  output logic          irq_o
);
  logic [DW-1:0] status_q, status_d;
  logic [DW-1:0] mask_q, mask_d;
  logic          status_en, mask_en;

  // next state: a set on the same bit as a clear wins
  always_comb begin
    status_en = (set_i != '0) || (clr_i != '0);
    status_d  = (status_q & ~clr_i) | set_i;
    mask_en   = (mask_set_i != '0) || (mask_clr_i != '0);
    mask_d    = (mask_q & ~mask_clr_i) | mask_set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= RESET_MASK;
    end else begin
      if (status_en) status_q <= status_d;
      if (mask_en)   mask_q   <= mask_d;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = (status_q & ~mask_q) != '0;

  assert_trigger_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((status_q & $past(clr_i & ~set_i)) == '0));

  assert_disable_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_set_i != '0) |=> ((mask_q & $past(mask_set_i)) == $past(mask_set_i)));

  assert_enable_unmasks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_clr_i & ~mask_set_i) != '0) |=> ((mask_q & $past(mask_clr_i & ~mask_set_i)) == '0));
endmodule

// File: rtl/ipi_doorbell_fabric.sv
`timescale 1ns/1ps
module ipi_doorbell_fabric
  import ipi_pkg::*;
#(
  parameter int unsigned NUM_AGENTS = AGENTS,
  parameter int unsigned DW         = DATA_W,
  parameter int unsigned IDX_W      = $clog2(NUM_AGENTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic                  req_secure,
  input  logic [IDX_W-1:0]      req_agent,
  input  logic [2:0]            req_word,
  input  logic [DW-1:0]         req_wdata,
  output logic                  rsp_valid,
  output logic [1:0]            rsp_code,
  output logic [DW-1:0]         rsp_rdata,
  output logic [NUM_AGENTS-1:0] irq
);
  localparam logic [DW-1:0] VALID_IDS = DW'(all_ids(NUM_AGENTS));
  localparam int unsigned   FLAT_W    = NUM_AGENTS * DW;

  logic rst_sync_n;
  logic grant;
  logic [1:0] chk_code;

  ipi_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  ipi_access_check #(.NUM_AGENTS(NUM_AGENTS), .DW(DW), .IDX_W(IDX_W)) u_access_check (
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_secure (req_secure),
    .req_agent  (req_agent),
    .req_wdata  (req_wdata),
    .grant_o    (grant),
    .code_o     (chk_code)
  );

  // ---------------- write decode ----------------
  logic          wr_ok;
  logic [DW-1:0] wd_ids;
  logic [DW-1:0] local_id;

  assign wr_ok  = grant && req_write;
  assign wd_ids = req_wdata & VALID_IDS;

  always_comb begin
    local_id = '0;
    for (int unsigned a = 0; a < NUM_AGENTS; a++)
      if (req_agent == IDX_W'(a)) local_id = DW'(id_bit(a));
  end

  logic [FLAT_W-1:0] status_flat;
  logic [FLAT_W-1:0] mask_flat;

  for (genvar b = 0; b < NUM_AGENTS; b++) begin : g_slot
    localparam logic [DW-1:0] ID_B = DW'(id_bit(b));
    logic          own;
    logic [DW-1:0] set_v, clr_v, mset_v, mclr_v;

    always_comb begin
      own    = (req_agent == IDX_W'(b));
      set_v  = (wr_ok && (req_word == W_TRIG) && ((wd_ids & ID_B) != '0)) ? local_id : '0;
      clr_v  = (wr_ok && own && (req_word == W_STAT)) ? wd_ids : '0;
      mset_v = (wr_ok && own && (req_word == W_DIS))  ? wd_ids : '0;
      mclr_v = (wr_ok && own && (req_word == W_EN))   ? wd_ids : '0;
    end

    ipi_agent_slot #(.DW(DW), .RESET_MASK(VALID_IDS)) u_slot (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .set_i      (set_v),
      .clr_i      (clr_v),
      .mask_set_i (mset_v),
      .mask_clr_i (mclr_v),
      .status_o   (status_flat[b*DW +: DW]),
      .mask_o     (mask_flat[b*DW +: DW]),
      .irq_o      (irq[b])
    );
  end

  // ---------------- read path ----------------
  logic [DW-1:0] local_status, local_mask, local_outst, rd_d;

  always_comb begin
    local_status = '0;
    local_mask   = '0;
    local_outst  = '0;
    for (int unsigned b = 0; b < NUM_AGENTS; b++) begin
      if (req_agent == IDX_W'(b)) begin
        local_status = status_flat[b*DW +: DW];
        local_mask   = mask_flat[b*DW +: DW];
      end
      if ((status_flat[b*DW +: DW] & local_id) != '0)
        local_outst |= DW'(id_bit(b));
    end
    rd_d = '0;
    if (grant && !req_write) begin
      case (req_word)
        W_OUTST: rd_d = local_outst;
        W_STAT:  rd_d = local_status;
        W_MASK:  rd_d = local_mask;
        default: rd_d = '0;
      endcase
    end
  end

  // ---------------- response register ----------------
  logic          rsp_valid_q, rsp_valid_d;
  logic [1:0]    rsp_code_q, rsp_code_d;
  logic [DW-1:0] rsp_rdata_q;

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_code_d  = req_valid ? chk_code : RSP_OK;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid_q <= 1'b0;
      rsp_code_q  <= RSP_OK;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_code_q  <= rsp_code_d;
      rsp_rdata_q <= rd_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_code  = rsp_code_q;
  assign rsp_rdata = rsp_rdata_q;

  assert_resp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_resp_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !rsp_valid);

  assert_range_refused_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && (req_agent >= IDX_W'(NUM_AGENTS))) |=> (rsp_code == RSP_RANGE));

  assert_refused_zero_data_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && (rsp_code != RSP_OK)) |-> (rsp_rdata == '0));

  assert_refused_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !grant) |=> ($stable(status_flat) && $stable(mask_flat)));

  assert_irq_needs_pending_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq != '0) |-> (status_flat != '0));
endmodule

// File: tb/ipi_doorbell_fabric_bench.sv
`timescale 1ns/1ps
module ipi_doorbell_fabric_bench;

  typedef struct packed {
    logic        wr;
    logic        sec;
    logic [3:0]  agt;
    logic [2:0]  word;
    logic [31:0] wd;
    logic [1:0]  ecode;
    logic [31:0] erd;
    logic [10:0] eirq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  // word: 0 trig, 1 outstanding, 4 status, 5 mask, 6 enable, 7 disable
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,4'd0, 3'd5,32'h00000000,2'd0,32'h0F0F0301,11'h000,4'd1},  // R1 reset mask
    '{1'b1,1'b0,4'd0, 3'd0,32'h00000100,2'd0,32'h00000000,11'h000,4'd2},  // R2 A0 rings A1
    '{1'b0,1'b0,4'd0, 3'd1,32'h00000000,2'd0,32'h00000100,11'h000,4'd3},  // R3
    '{1'b0,1'b0,4'd1, 3'd4,32'h00000000,2'd0,32'h00000001,11'h000,4'd2},  // R2
    '{1'b1,1'b0,4'd1, 3'd6,32'h00000001,2'd0,32'h00000000,11'h002,4'd6},  // R6
    '{1'b0,1'b0,4'd1, 3'd5,32'h00000000,2'd0,32'h0F0F0300,11'h002,4'd5},  // R5
    '{1'b1,1'b0,4'd1, 3'd4,32'h00000001,2'd0,32'h00000000,11'h000,4'd4},  // R4 ack
    '{1'b0,1'b0,4'd0, 3'd1,32'h00000000,2'd0,32'h00000000,11'h000,4'd4},  // R4 outstanding gone
    '{1'b1,1'b0,4'd7, 3'd0,32'h8C000200,2'd0,32'h00000000,11'h000,4'd11}, // R11 junk bit 31
    '{1'b0,1'b0,4'd9, 3'd4,32'h00000000,2'd0,32'h01000000,11'h000,4'd2},  // R2 multicast
    '{1'b0,1'b0,4'd7, 3'd1,32'h00000000,2'd0,32'h0C000200,11'h000,4'd3},  // R3 multiple
    '{1'b1,1'b0,4'd9, 3'd6,32'h01000000,2'd0,32'h00000000,11'h200,4'd6},  // R6
    '{1'b1,1'b0,4'd9, 3'd7,32'h01000000,2'd0,32'h00000000,11'h000,4'd5},  // R5 disable
    '{1'b0,1'b0,4'd7, 3'd0,32'h00000000,2'd0,32'h00000000,11'h000,4'd7},  // R7 trig reads 0
    '{1'b0,1'b0,4'd9, 3'd6,32'h00000000,2'd0,32'h00000000,11'h000,4'd7},  // R7 enable reads 0
    '{1'b1,1'b1,4'd0, 3'd3,32'hFFFFFFFF,2'd0,32'h00000000,11'h000,4'd7},  // R7 unused write
    '{1'b0,1'b0,4'd0, 3'd5,32'h00000000,2'd0,32'h0F0F0301,11'h000,4'd7},  // R7 no effect
    '{1'b0,1'b0,4'd0, 3'd2,32'h00000000,2'd0,32'h00000000,11'h000,4'd7},  // R7 unused read
    '{1'b0,1'b0,4'd11,3'd4,32'h00000000,2'd1,32'h00000000,11'h000,4'd8},  // R8
    '{1'b1,1'b0,4'd15,3'd0,32'h00000001,2'd1,32'h00000000,11'h000,4'd8},  // R8
    '{1'b0,1'b0,4'd0, 3'd4,32'h00000000,2'd0,32'h00000000,11'h000,4'd8},  // R8 no effect
    '{1'b0,1'b0,4'd3, 3'd4,32'h00000000,2'd2,32'h00000000,11'h000,4'd9},  // R9 local sec
    '{1'b1,1'b0,4'd0, 3'd0,32'h00010000,2'd2,32'h00000000,11'h000,4'd9},  // R9 remote sec
    '{1'b0,1'b1,4'd3, 3'd4,32'h00000000,2'd0,32'h00000000,11'h000,4'd9},  // R9 no effect
    '{1'b1,1'b1,4'd0, 3'd0,32'h00010000,2'd0,32'h00000000,11'h000,4'd9},  // R9 secure ok
    '{1'b0,1'b1,4'd3, 3'd4,32'h00000000,2'd0,32'h00000001,11'h000,4'd9},  // R9
    '{1'b1,1'b1,4'd3, 3'd6,32'h00000001,2'd0,32'h00000000,11'h008,4'd9},  // R9
    '{1'b1,1'b0,4'd3, 3'd4,32'h00000001,2'd2,32'h00000000,11'h008,4'd9},  // R9 refused ack
    '{1'b1,1'b1,4'd3, 3'd4,32'h00000001,2'd0,32'h00000000,11'h000,4'd4},  // R4 secure ack
    '{1'b0,1'b1,4'd0, 3'd1,32'h00000000,2'd0,32'h00000000,11'h000,4'd4}   // R4
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_secure;
  logic [3:0]  req_agent;
  logic [2:0]  req_word;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_rdata;
  logic [10:0] irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ipi_doorbell_fabric u_ipi_doorbell_fabric (
    .clk, .rst_n, .req_valid, .req_write, .req_secure, .req_agent,
    .req_word, .req_wdata, .rsp_valid, .rsp_code, .rsp_rdata, .irq
  );

  task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; req_write = 1'b0; req_secure = 1'b0;
    req_agent = '0; req_word = '0; req_wdata = '0;
  endtask

  task automatic access(input logic wr, input logic sec, input logic [3:0] agt,
                        input logic [2:0] word, input logic [31:0] wd);
    req_valid = 1'b1; req_write = wr; req_secure = sec;
    req_agent = agt; req_word = word; req_wdata = wd;
    @(negedge clk);
    idle();
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs quiet after reset
    chk("R1 reset irq/rsp_valid", {68'd0, irq, rsp_valid}, {68'd0, 11'h000, 1'b0});

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].sec, VEC[i].agt, VEC[i].word, VEC[i].wd);
      chk($sformatf("R%0d vector %0d", VEC[i].req, i),
          {34'd0, rsp_valid, rsp_code, rsp_rdata, irq},
          {34'd0, 1'b1, VEC[i].ecode, VEC[i].erd, VEC[i].eirq});
    end

    // R10: idle cycle gives no response
    @(negedge clk);
    chk("R10 no response when idle", {79'd0, rsp_valid}, {79'd0, 1'b0});

    // R6: A2 holds a request from A7; enabling it raises irq[2]
    access(1'b1, 1'b0, 4'd2, 3'd6, 32'h01000000);
    chk("R6 irq after enable", {69'd0, irq}, {69'd0, 11'h004});

    // R1: asynchronous reset in mid-run clears state and outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 irq low in reset", {68'd0, irq, rsp_valid}, {68'd0, 11'h000, 1'b0});
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    access(1'b0, 1'b0, 4'd2, 3'd4, 32'h0);
    chk("R1 status cleared by reset", {48'd0, rsp_rdata}, {48'd0, 32'h00000000});
    access(1'b0, 1'b0, 4'd2, 3'd5, 32'h0);
    chk("R1 mask restored by reset", {48'd0, rsp_rdata}, {48'd0, 32'h0F0F0301});

    // R10: back-to-back write then read; write returns zero data
    access(1'b1, 1'b0, 4'd10, 3'd0, 32'h00000001);
    chk("R10 write rdata zero", {47'd0, rsp_valid, rsp_rdata}, {47'd0, 1'b1, 32'h0});
    access(1'b0, 1'b0, 4'd0, 3'd4, 32'h0);
    chk("R2 A10 rings A0", {48'd0, rsp_rdata}, {48'd0, 32'h08000000});

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule